// File: doc/BRIEF.md
# ACPI Power-State Sequencer

This controller decides which rails and power switches of a memory/standby supply subsystem are on for each ACPI sleep state. It samples four already debounced logic inputs (master enable, sleep request, USB-in-standby request and a 5 V main-rail-good flag) and drives the gate controls for the dual-rail and USB switches, the main-rail blocking switch and the enables for the always-on 3.3 V linear regulator, the VDDQ switching regulator and the VTT termination regulator.

After power-on, or after the supply-undervoltage input pulses, the block ignores its logic inputs for a programmable blanking count, which stands in for the time the soft-start capacitor needs. It then tracks the requested state. Entry to the fully-on state waits for the main-rail-good flag. VDDQ starts only after a settle count of main-good cycles outside the off state. VTT follows only in the fully-on state with VDDQ reported good.

Top module: `acpi_seq_ctrl`

## Requirements
- R1: From reset, and for BLANK_CYCLES clock edges after it, `state_o` is 2'b00 (off) with off-state outputs whatever the logic inputs are; the first edge that may change the state is edge BLANK_CYCLES+1.
- R2: In the off state (`state_o`=2'b00, entered when `pwr_en_i` is low) `dual_sw_o`=1, `usb_sw_n_o`=1, `main_gate_o`=0, `ldo_aon_en_o`=1, `vddq_en_o`=0, `vtt_en_o`=0.
- R3: With `pwr_en_i`=1, `sleep_n_i`=0, `usb_stby_n_i`=0 the state becomes standby-without-USB (`state_o`=2'b01): `dual_sw_o`=0, `usb_sw_n_o`=1, `main_gate_o`=0, `ldo_aon_en_o`=1.
- R4: With `pwr_en_i`=1, `sleep_n_i`=0, `usb_stby_n_i`=1 the state becomes suspend (`state_o`=2'b10): `dual_sw_o`=0, `usb_sw_n_o`=0, `main_gate_o`=0, `ldo_aon_en_o`=1.
- R5: In the working state (`state_o`=2'b11) `dual_sw_o`, `usb_sw_n_o` and `main_gate_o` are 1 and `ldo_aon_en_o` is 0.
- R6: With `pwr_en_i`=1 and `sleep_n_i`=1 the working state is entered only on an edge where `main5_ok_i` is 1; otherwise the present state is held. Once in the working state it is kept while both stay high.
- R7: Drive modes are 2'b00 released, 2'b01 weak current sink, 2'b10 strong pull-down. A switch pulled low uses 2'b10 while `main5_ok_i` is 1 and 2'b01 otherwise; a released switch shows 2'b00; 2'b11 never appears.
- R8: A settle counter clears while the state is off or blanking and advances on each edge with `main5_ok_i`=1; `vddq_en_o` is 1 when it has reached SETTLE_CYCLES and the state is not off.
- R9: `vtt_en_o` is 1 exactly when `vddq_en_o` is 1, the state is working, and `vddq_ok_i` is 1.
- R10: `vcc_uvlo_i` high at an edge acts as a synchronous reset: the state returns to off, the settle counter clears and blanking restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_uvlo_i | input | 1 | Supply undervoltage, synchronous restart |
| pwr_en_i | input | 1 | Master enable (low = off state) |
| sleep_n_i | input | 1 | Low requests a sleep state |
| usb_stby_n_i | input | 1 | High keeps USB powered in sleep |
| main5_ok_i | input | 1 | 5 V main rail above threshold |
| vddq_ok_i | input | 1 | VDDQ soft-start complete flag |
| dual_sw_o | output | 1 | Dual-rail standby switch gate, low = on |
| usb_sw_n_o | output | 1 | USB standby switch gate, low = on |
| main_gate_o | output | 1 | Main-rail blocking switch gate, high = on |
| dual_mode_o | output | 2 | Drive mode of dual_sw_o |
| usb_mode_o | output | 2 | Drive mode of usb_sw_n_o |
| ldo_aon_en_o | output | 1 | Always-on 3.3 V regulator enable |
| vddq_en_o | output | 1 | VDDQ switcher enable |
| vtt_en_o | output | 1 | VTT regulator enable |
| state_o | output | 2 | Decoded power state |

## Verification
The bench drives requests during blanking, and a design that sampled them early would leave the off state too soon. It raises the sleep request while the main rail is still low, where a controller without the gate would release the blocking switch and drop the standby regulator onto a dead rail. It holds the main flag low in suspend to confirm that the settle count stalls and VDDQ stays off, and it pulses undervoltage mid-run to show that blanking restarts rather than resuming the old state. Long stretches of pseudo-random inputs then check the weak and strong drive-mode choice and the VTT gating every cycle.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;
  typedef enum logic [1:0] {
    PS_OFF  = 2'b00,
    PS_SBNU = 2'b01,
    PS_SUSP = 2'b10,
    PS_WORK = 2'b11
  } pstate_e;

  typedef enum logic [1:0] {
    DRV_REL    = 2'b00,
    DRV_WEAK   = 2'b01,
    DRV_STRONG = 2'b10
  } drv_e;
endpackage

// File: rtl/acpi_seq_cnt.sv
module acpi_seq_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (inc_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/acpi_seq_fsm.sv
module acpi_seq_fsm
  import acpi_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    uvlo_i,
  input  logic    run_i,
  input  logic    pwr_en_i,
  input  logic    sleep_n_i,
  input  logic    usb_stby_n_i,
  input  logic    main5_ok_i,
  output pstate_e state_o
);
  pstate_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (uvlo_i || !run_i || !pwr_en_i)  st_d = PS_OFF;
    else if (!sleep_n_i)                st_d = usb_stby_n_i ? PS_SUSP : PS_SBNU;
    else if (st_q == PS_WORK || main5_ok_i) st_d = PS_WORK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PS_OFF;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/acpi_seq_dec.sv
module acpi_seq_dec
  import acpi_seq_pkg::*;
(
  input  pstate_e     state_i,
  input  logic        main5_ok_i,
  input  logic        settled_i,
  input  logic        vddq_ok_i,
  output logic        dual_sw_o,
  output logic        usb_sw_n_o,
  output logic        main_gate_o,
  output logic [1:0]  dual_mode_o,
  output logic [1:0]  usb_mode_o,
  output logic        ldo_aon_en_o,
  output logic        vddq_en_o,
  output logic        vtt_en_o
);
  drv_e pull_mode;
  drv_e dual_m, usb_m;

  // weak sink limits inrush while the main rail is still down
  assign pull_mode = main5_ok_i ? DRV_STRONG : DRV_WEAK;

  always_comb begin
    dual_m       = DRV_REL;
    usb_m        = DRV_REL;
    main_gate_o  = 1'b0;
    ldo_aon_en_o = 1'b1;
    unique case (state_i)
      PS_OFF:  ;
      PS_SBNU: dual_m = pull_mode;
      PS_SUSP: begin
        dual_m = pull_mode;
        usb_m  = pull_mode;
      end
      PS_WORK: begin
        main_gate_o  = 1'b1;
        ldo_aon_en_o = 1'b0;
      end
      default: ;
    endcase
  end

  assign dual_mode_o = dual_m;
  assign usb_mode_o  = usb_m;
  assign dual_sw_o   = (dual_m == DRV_REL);
  assign usb_sw_n_o  = (usb_m == DRV_REL);
  assign vddq_en_o   = settled_i && (state_i != PS_OFF);
  assign vtt_en_o    = vddq_en_o && (state_i == PS_WORK) && vddq_ok_i;
endmodule

// File: rtl/acpi_seq_ctrl.sv
module acpi_seq_ctrl
  import acpi_seq_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES  = 85000,
  parameter int unsigned SETTLE_CYCLES = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_uvlo_i,
  input  logic       pwr_en_i,
  input  logic       sleep_n_i,
  input  logic       usb_stby_n_i,
  input  logic       main5_ok_i,
  input  logic       vddq_ok_i,
  output logic       dual_sw_o,
  output logic       usb_sw_n_o,
  output logic       main_gate_o,
  output logic [1:0] dual_mode_o,
  output logic [1:0] usb_mode_o,
  output logic       ldo_aon_en_o,
  output logic       vddq_en_o,
  output logic       vtt_en_o,
  output logic [1:0] state_o
);
  logic    run, settled, settle_clr;
  pstate_e st;

  acpi_seq_cnt #(.LIMIT(BLANK_CYCLES)) i_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vcc_uvlo_i),
    .inc_i  (1'b1),
    .done_o (run)
  );

  acpi_seq_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .uvlo_i       (vcc_uvlo_i),
    .run_i        (run),
    .pwr_en_i     (pwr_en_i),
    .sleep_n_i    (sleep_n_i),
    .usb_stby_n_i (usb_stby_n_i),
    .main5_ok_i   (main5_ok_i),
    .state_o      (st)
  );

  assign settle_clr = vcc_uvlo_i || !run || (st == PS_OFF);

  acpi_seq_cnt #(.LIMIT(SETTLE_CYCLES)) i_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (settle_clr),
    .inc_i  (main5_ok_i),
    .done_o (settled)
  );

  acpi_seq_dec i_dec (
    .state_i      (st),
    .main5_ok_i   (main5_ok_i),
    .settled_i    (settled),
    .vddq_ok_i    (vddq_ok_i),
    .dual_sw_o    (dual_sw_o),
    .usb_sw_n_o   (usb_sw_n_o),
    .main_gate_o  (main_gate_o),
    .dual_mode_o  (dual_mode_o),
    .usb_mode_o   (usb_mode_o),
    .ldo_aon_en_o (ldo_aon_en_o),
    .vddq_en_o    (vddq_en_o),
    .vtt_en_o     (vtt_en_o)
  );

  assign state_o = st;
endmodule

// File: rtl/acpi_seq_chk.sv
module acpi_seq_chk #(
  parameter int unsigned BLANK_CYCLES = 85000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vcc_uvlo_i,
  input logic       main5_ok_i,
  input logic       vddq_ok_i,
  input logic       dual_sw_o,
  input logic       usb_sw_n_o,
  input logic       main_gate_o,
  input logic [1:0] dual_mode_o,
  input logic [1:0] usb_mode_o,
  input logic       ldo_aon_en_o,
  input logic       vddq_en_o,
  input logic       vtt_en_o,
  input logic [1:0] state_o
);
  localparam int unsigned W = $clog2(BLANK_CYCLES + 1);
  localparam logic [W-1:0] LIM = W'(BLANK_CYCLES);

  logic [W-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           since_q <= '0;
    else if (vcc_uvlo_i)   since_q <= '0;
    else if (since_q != LIM) since_q <= since_q + 1'b1;
  end

  // R1
  blank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || vcc_uvlo_i)
    (since_q < LIM) |-> (state_o == 2'b00 && !vddq_en_o));

  // R5
  work_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_gate_o |-> (!ldo_aon_en_o && dual_sw_o && usb_sw_n_o));

  // R6
  work_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b11 && $past(state_o) != 2'b11) |-> $past(main5_ok_i));

  // R7
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_mode_o != 2'b11) && (usb_mode_o != 2'b11) &&
    ((dual_mode_o == 2'b00) == dual_sw_o) && ((usb_mode_o == 2'b00) == usb_sw_n_o));

  // R8
  vddq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vddq_en_o) |-> $past(main5_ok_i));

  // R9
  vtt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtt_en_o |-> (vddq_en_o && vddq_ok_i && state_o == 2'b11));

  // R10
  uvlo_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vcc_uvlo_i) |-> (state_o == 2'b00 && !vddq_en_o));
endmodule

bind acpi_seq_ctrl acpi_seq_chk #(.BLANK_CYCLES(BLANK_CYCLES)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vcc_uvlo_i   (vcc_uvlo_i),
  .main5_ok_i   (main5_ok_i),
  .vddq_ok_i    (vddq_ok_i),
  .dual_sw_o    (dual_sw_o),
  .usb_sw_n_o   (usb_sw_n_o),
  .main_gate_o  (main_gate_o),
  .dual_mode_o  (dual_mode_o),
  .usb_mode_o   (usb_mode_o),
  .ldo_aon_en_o (ldo_aon_en_o),
  .vddq_en_o    (vddq_en_o),
  .vtt_en_o     (vtt_en_o),
  .state_o      (state_o)
);

// File: tb/test_acpi_seq_ctrl.sv
`timescale 1ns/1ps
module test_acpi_seq_ctrl;
  localparam int BLANK  = 20;
  localparam int SETTLE = 12;

  logic clk = 0, rst_n = 0, uvlo = 0;
  logic en = 1, sleep_n = 1, usb_n = 1, main_ok = 1, vq_ok = 0;
  logic dual_sw, usb_sw_n, main_gate, ldo_en, vddq_en, vtt_en;
  logic [1:0] dual_mode, usb_mode, state;

  int checks = 0, errors = 0;
  int m_blank = 0, m_settle = 0, m_st = 0;

  always #10 clk = ~clk;

  acpi_seq_ctrl #(.BLANK_CYCLES(BLANK), .SETTLE_CYCLES(SETTLE)) i_acpi_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .vcc_uvlo_i(uvlo), .pwr_en_i(en), .sleep_n_i(sleep_n),
    .usb_stby_n_i(usb_n), .main5_ok_i(main_ok), .vddq_ok_i(vq_ok),
    .dual_sw_o(dual_sw), .usb_sw_n_o(usb_sw_n), .main_gate_o(main_gate),
    .dual_mode_o(dual_mode), .usb_mode_o(usb_mode), .ldo_aon_en_o(ldo_en),
    .vddq_en_o(vddq_en), .vtt_en_o(vtt_en), .state_o(state));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: state codes 0 off, 1 standby-no-usb, 2 suspend, 3 working
  always @(posedge clk) begin
    int nst;
    bit run;
    if (!rst_n) begin
      m_blank = 0; m_settle = 0; m_st = 0;
    end else if (uvlo) begin
      m_blank = 0; m_settle = 0; m_st = 0;
    end else begin
      run = (m_blank >= BLANK);
      if (!run || !en) nst = 0;
      else if (!sleep_n) nst = usb_n ? 2 : 1;
      else if (m_st == 3 || main_ok) nst = 3;
      else nst = m_st;
      if (!run || m_st == 0) m_settle = 0;
      else if (main_ok && m_settle < SETTLE) m_settle++;
      if (m_blank < BLANK) m_blank++;
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    int e_dual, e_usb, e_gate, e_ldo, e_dm, e_um, e_vq, e_vt, pull;
    string tag;
    if (rst_n) begin
      pull = main_ok ? 2 : 1;
      case (m_st)
        0: begin e_dual = 1; e_usb = 1; e_gate = 0; e_ldo = 1; e_dm = 0;    e_um = 0;    end
        1: begin e_dual = 0; e_usb = 1; e_gate = 0; e_ldo = 1; e_dm = pull; e_um = 0;    end
        2: begin e_dual = 0; e_usb = 0; e_gate = 0; e_ldo = 1; e_dm = pull; e_um = pull; end
        default: begin e_dual = 1; e_usb = 1; e_gate = 1; e_ldo = 0; e_dm = 0; e_um = 0; end
      endcase
      e_vq = (m_settle == SETTLE) && (m_st != 0);
      e_vt = e_vq && (m_st == 3) && vq_ok;
      tag = (m_blank < BLANK) ? "R1" : (m_st == 0) ? "R2" : (m_st == 1) ? "R3" :
            (m_st == 2) ? "R4" : "R5";
      chk(state == m_st, {tag, " state"}, state, m_st);
      chk({dual_sw, usb_sw_n, main_gate, ldo_en} == {e_dual[0], e_usb[0], e_gate[0], e_ldo[0]},
          {tag, " pins"}, {dual_sw, usb_sw_n, main_gate, ldo_en},
          {e_dual[0], e_usb[0], e_gate[0], e_ldo[0]});
      chk(dual_mode == e_dm && usb_mode == e_um, "R7 modes", {dual_mode, usb_mode}, e_dm*4 + e_um);
      chk(vddq_en == e_vq, "R8 vddq_en", vddq_en, e_vq);
      chk(vtt_en == e_vt, "R9 vtt_en", vtt_en, e_vt);
    end
  end

  task automatic at_edge();
    @(posedge clk); #2;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lfsr = 32'h1ace;
    wait_neg(3);
    chk(state == 0 && ldo_en && !vddq_en && dual_sw && !main_gate, "R1 reset", state, 0);
    at_edge(); rst_n = 1;
    wait_neg(10);
    chk(state == 0, "R1 inputs ignored in blanking", state, 0);
    wait_neg(15);
    chk(state == 3 && !ldo_en, "R5 working after blanking", state, 3);
    wait_neg(20);
    chk(vddq_en == 1, "R8 vddq after settle", vddq_en, 1);
    chk(vtt_en == 0, "R9 vtt waits for vddq ok", vtt_en, 0);
    at_edge(); vq_ok = 1;
    wait_neg(1);
    chk(vtt_en == 1, "R9 vtt on", vtt_en, 1);
    at_edge(); sleep_n = 0;
    wait_neg(2);
    chk(state == 2 && dual_mode == 2 && usb_mode == 2, "R4 suspend strong", state, 2);
    chk(vtt_en == 0, "R9 vtt off in suspend", vtt_en, 0);
    at_edge(); main_ok = 0;
    wait_neg(1);
    chk(dual_mode == 1 && usb_mode == 1, "R7 weak sink", {dual_mode, usb_mode}, 5);
    at_edge(); usb_n = 0;
    wait_neg(2);
    chk(state == 1 && usb_sw_n, "R3 standby no usb", state, 1);
    at_edge(); sleep_n = 1;
    wait_neg(5);
    chk(state == 1 && !main_gate, "R6 held without main ok", state, 1);
    at_edge(); main_ok = 1;
    wait_neg(2);
    chk(state == 3, "R6 working after main ok", state, 3);
    at_edge(); en = 0;
    wait_neg(2);
    chk(state == 0 && !vddq_en, "R2 off", state, 0);
    at_edge(); en = 1; sleep_n = 0; usb_n = 1; main_ok = 0;
    wait_neg(30);
    chk(state == 2 && !vddq_en, "R8 settle stalls without main", vddq_en, 0);
    at_edge(); main_ok = 1;
    wait_neg(20);
    chk(vddq_en == 1, "R8 settle resumes", vddq_en, 1);
    at_edge(); uvlo = 1;
    wait_neg(2);
    chk(state == 0 && !vddq_en, "R10 uvlo restart", state, 0);
    at_edge(); uvlo = 0;
    wait_neg(5);
    chk(state == 0, "R10 blanking again", state, 0);
    wait_neg(25);
    chk(state == 2, "R10 resumes after blanking", state, 2);
    for (int i = 0; i < 3000; i++) begin
      at_edge();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h0) begin
        en = lfsr[4]; sleep_n = lfsr[5]; usb_n = lfsr[6];
      end
      if (lfsr[9:7] == 3'b000) main_ok = lfsr[10];
      if (lfsr[13:11] == 3'b000) vq_ok = lfsr[14];
      uvlo = (lfsr[24:16] == 9'h0);
    end
    at_edge(); uvlo = 0;
    wait_neg(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule